// File: doc/BRIEF.md
# Tagged-Pointer Shared Memory Controller

This block sits between a datapath that issues loads and stores through 32-bit pointers and a set of on-chip block RAMs, one RAM per array. The top nine pointer bits are a memory tag that names the array, and the low twenty-three bits are the element index inside it. Each RAM is as wide as the elements it holds. Because each RAM's read port is registered, the tag of every accepted read is registered too. That registered tag steers the return multiplexer one cycle later.

Two tag values are reserved. Tag zero marks a null pointer. Any access through it raises a one-cycle error flag and touches nothing. Tag one marks memory outside the chip. Such an access is passed to an external request port with a valid/ready handshake. The controller accepts no new request until the external side has taken the request and, for a read, has returned the data. An index at or past the depth of its RAM raises an out-of-range flag, and so does a tag that names no RAM. Either way nothing is read or written.

Top module: `tagmem_ctrl`

## Requirements
- R1: A pointer splits into a tag in bits 31:23 and an index in bits 22:0. Tag value t ≥ 2 selects on-chip RAM number t-2, and the index is used unchanged as that RAM's word address. With the default sizes, RAMs 0, 1 and 2 (tags 2, 3, 4) hold 16, 8 and 32 elements of 32, 16 and 8 bits.
- R2: A read accepted in cycle k (req_valid and req_ready high at the rising edge) raises rsp_valid in cycle k+1. rsp_rdata then carries the stored element, zero-extended to 32 bits.
- R3: A write stores the low bits of req_wdata, as many as the RAM's element width. A write to one RAM leaves every other RAM unchanged.
- R4: An access with tag 0 raises null_err for exactly the cycle after acceptance. It produces no response, no external request and no write.
- R5: An access with tag 1 raises ext_req_valid in the cycle after acceptance, carrying the index, the write flag and the write data. These stay stable until ext_req_ready is sampled high, and req_ready is low for as long as the external transfer is open.
- R6: For an external read, an ext_rsp_valid sampled while the controller awaits data raises rsp_valid with that data in the next cycle, and req_ready returns high in the same cycle.
- R7: An external write closes on its handshake edge, and req_ready is high again in the following cycle.
- R8: An index at or past the depth of its RAM raises oor_err for the cycle after acceptance. It returns no response, and a write is dropped, so the location its low address bits alias is unchanged.
- R9: A tag of 2 + (number of RAMs) or higher, up to 511, raises oor_err and produces no response.
- R10: Reads and writes can follow each other every cycle. A read followed at once by a write to the same location returns the old value. Back-to-back reads of different RAMs each return their own RAM's data.
- R11: While reset is high, rsp_valid, null_err, oor_err and ext_req_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Tagged pointer |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data, zero-extended |
| null_err | output | 1 | One-cycle pulse: null pointer used |
| oor_err | output | 1 | One-cycle pulse: index or tag out of range |
| ext_req_valid | output | 1 | External request present |
| ext_req_ready | input | 1 | External side takes the request |
| ext_req_we | output | 1 | External request is a store |
| ext_req_addr | output | 23 | External element index |
| ext_req_wdata | output | 32 | External store data |
| ext_rsp_valid | input | 1 | External load data valid |
| ext_rsp_rdata | input | 32 | External load data |

## Verification
A read and a write can land in the same cycle. A read's data leaves the RAM on the edge at which the next request, a write to the same location, is already entering it. The bench provokes this by issuing the write in the cycle right after the read. It also issues reads of different RAMs on consecutive cycles, and an on-chip read right behind an external read that is still waiting for data. A behavioural model keeps a per-RAM store and a small state for the external transfer. It predicts every output on every clock, and a correct result is the old value returned, the new value stored, and each reply steered from the RAM its own request named.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

  // classification of one decoded pointer
  typedef enum logic [1:0] {
    ACC_NULL = 2'd0,
    ACC_EXT  = 2'd1,
    ACC_BANK = 2'd2,
    ACC_MISS = 2'd3
  } acc_kind_e;

  // external transfer progress
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } ext_state_e;

  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/tagmem_decode.sv
module tagmem_decode
  import tagmem_pkg::*;
#(
  parameter int TAG_W      = 9,
  parameter int IDX_W      = 23,
  parameter int NUM_BANKS  = 3,
  parameter int BANK_DEPTH [NUM_BANKS] = '{16, 8, 32}
) (
  input  logic [TAG_W+IDX_W-1:0] addr,
  output logic [TAG_W-1:0]       tag,
  output logic [IDX_W-1:0]       idx,
  output logic [NUM_BANKS-1:0]   bank_hit,
  output acc_kind_e              kind
);

  localparam int FIRST_BANK_TAG = 2;

  logic [NUM_BANKS-1:0] in_range;

  assign tag = addr[TAG_W+IDX_W-1:IDX_W];
  assign idx = addr[IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = (tag == TAG_W'(b + FIRST_BANK_TAG));
    assign in_range[b] = (idx < IDX_W'(BANK_DEPTH[b]));
  end

  always_comb begin
    if (tag == '0) begin
      kind = ACC_NULL;
    end else if (tag == TAG_W'(1)) begin
      kind = ACC_EXT;
    end else if ((bank_hit & in_range) != '0) begin
      kind = ACC_BANK;
    end else begin
      kind = ACC_MISS;
    end
  end

endmodule

// File: rtl/tagmem_bank.sv
module tagmem_bank
  import tagmem_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW   = addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // read-first single port, registered output
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/tagmem_ext.sv
module tagmem_ext
  import tagmem_pkg::*;
#(
  parameter int IDX_W  = 23,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              idle,
  output logic              ext_req_valid,
  input  logic              ext_req_ready,
  output logic              ext_req_we,
  output logic [IDX_W-1:0]  ext_req_addr,
  output logic [DATA_W-1:0] ext_req_wdata,
  input  logic              ext_rsp_valid,
  input  logic [DATA_W-1:0] ext_rsp_rdata,
  output logic              rsp_pulse,
  output logic [DATA_W-1:0] rsp_data
);

  ext_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= XS_IDLE;
      ext_req_we    <= 1'b0;
      ext_req_addr  <= '0;
      ext_req_wdata <= '0;
      rsp_pulse     <= 1'b0;
      rsp_data      <= '0;
    end else begin
      rsp_pulse <= 1'b0;
      unique case (state_q)
        XS_IDLE: begin
          if (start) begin
            state_q       <= XS_REQ;
            ext_req_we    <= start_we;
            ext_req_addr  <= start_idx;
            ext_req_wdata <= start_wdata;
          end
        end
        XS_REQ: begin
          if (ext_req_ready) begin
            state_q <= ext_req_we ? XS_IDLE : XS_WAIT;
          end
        end
        XS_WAIT: begin
          if (ext_rsp_valid) begin
            state_q   <= XS_IDLE;
            rsp_pulse <= 1'b1;
            rsp_data  <= ext_rsp_rdata;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign idle          = (state_q == XS_IDLE);
  assign ext_req_valid = (state_q == XS_REQ);

endmodule

// File: rtl/tagmem_rmux.sv
module tagmem_rmux #(
  parameter int TAG_W     = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 3
) (
  input  logic [TAG_W-1:0]  sel_tag,
  input  logic [DATA_W-1:0] bank_rd [NUM_BANKS],
  input  logic              use_ext,
  input  logic [DATA_W-1:0] ext_rd,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (use_ext) begin
      rdata = ext_rd;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (sel_tag == TAG_W'(b + 2)) begin
          rdata = bank_rd[b];
        end
      end
    end
  end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
  import tagmem_pkg::*;
#(
  parameter int TAG_W     = 9,
  parameter int IDX_W     = 23,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 3,
  parameter int BANK_DEPTH [NUM_BANKS] = '{16, 8, 32},
  parameter int BANK_WIDTH [NUM_BANKS] = '{32, 16, 8}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [TAG_W+IDX_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   null_err,
  output logic                   oor_err,
  output logic                   ext_req_valid,
  input  logic                   ext_req_ready,
  output logic                   ext_req_we,
  output logic [IDX_W-1:0]       ext_req_addr,
  output logic [DATA_W-1:0]      ext_req_wdata,
  input  logic                   ext_rsp_valid,
  input  logic [DATA_W-1:0]      ext_rsp_rdata
);

  logic                 fire;
  logic [TAG_W-1:0]     dec_tag;
  logic [IDX_W-1:0]     dec_idx;
  logic [NUM_BANKS-1:0] dec_hit;
  acc_kind_e            dec_kind;

  logic                 bank_rsp_q;
  logic                 null_q;
  logic                 oor_q;
  logic [TAG_W-1:0]     sel_tag_q;

  logic                 ext_idle;
  logic                 ext_rsp_q;
  logic [DATA_W-1:0]    ext_data_q;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  assign fire = req_valid && req_ready;

  tagmem_decode #(
    .TAG_W      (TAG_W),
    .IDX_W      (IDX_W),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_DEPTH (BANK_DEPTH)
  ) u_decode (
    .addr     (req_addr),
    .tag      (dec_tag),
    .idx      (dec_idx),
    .bank_hit (dec_hit),
    .kind     (dec_kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W  = BANK_WIDTH[b];
    localparam int AW = addr_bits(BANK_DEPTH[b]);
    logic          en;
    logic [W-1:0]  rd;

    assign en = fire && (dec_kind == ACC_BANK) && dec_hit[b];

    tagmem_bank #(
      .WIDTH (W),
      .DEPTH (BANK_DEPTH[b])
    ) u_bank (
      .clk   (clk),
      .en    (en),
      .we    (en && req_we),
      .addr  (dec_idx[AW-1:0]),
      .wdata (req_wdata[W-1:0]),
      .rdata (rd)
    );

    assign bank_rd[b] = DATA_W'(rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_rsp_q <= 1'b0;
      null_q     <= 1'b0;
      oor_q      <= 1'b0;
      sel_tag_q  <= '0;
    end else begin
      bank_rsp_q <= fire && (dec_kind == ACC_BANK) && !req_we;
      null_q     <= fire && (dec_kind == ACC_NULL);
      oor_q      <= fire && (dec_kind == ACC_MISS);
      if (fire && (dec_kind == ACC_BANK)) begin
        sel_tag_q <= dec_tag;
      end
    end
  end

  tagmem_ext #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_ext (
    .clk           (clk),
    .rst           (rst),
    .start         (fire && (dec_kind == ACC_EXT)),
    .start_we      (req_we),
    .start_idx     (dec_idx),
    .start_wdata   (req_wdata),
    .idle          (ext_idle),
    .ext_req_valid (ext_req_valid),
    .ext_req_ready (ext_req_ready),
    .ext_req_we    (ext_req_we),
    .ext_req_addr  (ext_req_addr),
    .ext_req_wdata (ext_req_wdata),
    .ext_rsp_valid (ext_rsp_valid),
    .ext_rsp_rdata (ext_rsp_rdata),
    .rsp_pulse     (ext_rsp_q),
    .rsp_data      (ext_data_q)
  );

  tagmem_rmux #(
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_rmux (
    .sel_tag (sel_tag_q),
    .bank_rd (bank_rd),
    .use_ext (ext_rsp_q),
    .ext_rd  (ext_data_q),
    .rdata   (rsp_rdata)
  );

  assign req_ready = ext_idle;
  assign rsp_valid = bank_rsp_q || ext_rsp_q;
  assign null_err  = null_q;
  assign oor_err   = oor_q;

endmodule

// File: rtl/tagmem_ctrl_chk.sv
module tagmem_ctrl_chk #(
  parameter int TAG_W       = 9,
  parameter int IDX_W       = 23,
  parameter int DATA_W      = 32,
  parameter int FIRST_DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_we,
  input logic [TAG_W+IDX_W-1:0] req_addr,
  input logic [DATA_W-1:0]      req_wdata,
  input logic                   rsp_valid,
  input logic [DATA_W-1:0]      rsp_rdata,
  input logic                   null_err,
  input logic                   oor_err,
  input logic                   ext_req_valid,
  input logic                   ext_req_ready,
  input logic                   ext_req_we,
  input logic [IDX_W-1:0]       ext_req_addr,
  input logic [DATA_W-1:0]      ext_req_wdata,
  input logic                   ext_rsp_valid,
  input logic [DATA_W-1:0]      ext_rsp_rdata
);

  logic             acc;
  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;

  assign acc   = req_valid && req_ready;
  assign a_tag = req_addr[TAG_W+IDX_W-1:IDX_W];
  assign a_idx = req_addr[IDX_W-1:0];

  assert_first_bank_read_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_we && a_tag == TAG_W'(2) && a_idx < IDX_W'(FIRST_DEPTH)) |=> rsp_valid);

  assert_null_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && a_tag == '0) |=> (null_err && !rsp_valid && !ext_req_valid));

  assert_ext_launch_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && a_tag == TAG_W'(1)) |=> (ext_req_valid && !req_ready && ext_req_addr == $past(a_idx)));

  assert_ext_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ext_req_valid && !ext_req_ready) |=>
      (ext_req_valid && $stable(ext_req_addr) && $stable(ext_req_we) && $stable(ext_req_wdata)));

  assert_ext_write_close_R7: assert property (@(posedge clk) disable iff (rst)
    (ext_req_valid && ext_req_ready && ext_req_we) |=> req_ready);

  assert_oor_no_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    oor_err |-> (!rsp_valid && !null_err));

  assert_miss_tag_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && a_tag >= TAG_W'(5)) |=> oor_err);

endmodule

bind tagmem_ctrl tagmem_ctrl_chk #(
  .TAG_W       (TAG_W),
  .IDX_W       (IDX_W),
  .DATA_W      (DATA_W),
  .FIRST_DEPTH (BANK_DEPTH[0])
) u_chk (.*);

// File: tb/tagmem_ctrl_bench.sv
module tagmem_ctrl_bench;

  localparam int NB = 3;
  localparam int DEP [NB] = '{16, 8, 32};
  localparam int WID [NB] = '{32, 16, 8};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        null_err;
  logic        oor_err;
  logic        ext_req_valid;
  logic        ext_req_ready = 1'b0;
  logic        ext_req_we;
  logic [22:0] ext_req_addr;
  logic [31:0] ext_req_wdata;
  logic        ext_rsp_valid = 1'b0;
  logic [31:0] ext_rsp_rdata = '0;

  always #2 clk = ~clk;

  tagmem_ctrl u_tagmem_ctrl (.*);

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R11";
  int    ext_lat = 0;
  int    rsp_lat = 0;

  // ---------------- reference model ----------------
  logic [31:0] mdl_mem [int];
  bit          e_rsp_v, e_rsp_known, e_null, e_oor, e_ready = 1'b1;
  logic [31:0] e_rsp_d;
  int          x_state = 0;  // 0 idle, 1 requesting, 2 waiting for data
  bit          e_x_we;
  logic [22:0] e_x_idx;
  logic [31:0] e_x_wd;

  always @(posedge clk) begin
    if (rst) begin
      e_rsp_v = 0; e_null = 0; e_oor = 0; x_state = 0; e_ready = 1;
    end else begin
      bit fire;
      int tg, ix, bk, key;
      fire = req_valid && e_ready;
      e_rsp_v = 0; e_null = 0; e_oor = 0;
      if (x_state == 1) begin
        if (ext_req_ready) x_state = e_x_we ? 0 : 2;
      end else if (x_state == 2) begin
        if (ext_rsp_valid) begin
          e_rsp_v = 1; e_rsp_known = 1; e_rsp_d = ext_rsp_rdata; x_state = 0;
        end
      end
      if (fire) begin
        tg = int'(req_addr[31:23]);
        ix = int'(req_addr[22:0]);
        bk = tg - 2;
        if (tg == 0) begin
          e_null = 1;
        end else if (tg == 1) begin
          x_state = 1; e_x_we = req_we; e_x_idx = req_addr[22:0]; e_x_wd = req_wdata;
        end else if (bk < NB && ix < DEP[bk]) begin
          key = bk * 4096 + ix;
          if (req_we) begin
            mdl_mem[key] = (WID[bk] == 32) ? req_wdata
                         : (req_wdata & ((32'd1 << WID[bk]) - 32'd1));
          end else begin
            e_rsp_v = 1;
            e_rsp_known = mdl_mem.exists(key);
            e_rsp_d = e_rsp_known ? mdl_mem[key] : '0;
          end
        end else begin
          e_oor = 1;
        end
      end
      e_ready = (x_state == 0);
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  initial begin
    @(posedge clk);
    forever begin
      @(negedge clk);
      cmp("req_ready", 32'(req_ready), 32'(e_ready));
      cmp("rsp_valid", 32'(rsp_valid), 32'(e_rsp_v));
      cmp("null_err", 32'(null_err), 32'(e_null));
      cmp("oor_err", 32'(oor_err), 32'(e_oor));
      cmp("ext_req_valid", 32'(ext_req_valid), 32'(x_state == 1));
      if (e_rsp_v && e_rsp_known) cmp("rsp_rdata", rsp_rdata, e_rsp_d);
      if (x_state == 1) begin
        cmp("ext_req_we", 32'(ext_req_we), 32'(e_x_we));
        cmp("ext_req_addr", 32'(ext_req_addr), 32'(e_x_idx));
        if (e_x_we) cmp("ext_req_wdata", ext_req_wdata, e_x_wd);
      end
    end
  end

  // ---------------- external responder ----------------
  initial begin
    forever begin
      @(negedge clk);
      ext_req_ready = 0;
      ext_rsp_valid = 0;
      if (ext_req_valid && !rst) begin
        bit          w;
        logic [22:0] a;
        repeat (ext_lat) @(negedge clk);
        ext_req_ready = 1;
        w = ext_req_we;
        a = ext_req_addr;
        @(negedge clk);
        ext_req_ready = 0;
        if (!w) begin
          repeat (rsp_lat) @(negedge clk);
          ext_rsp_valid = 1;
          ext_rsp_rdata = 32'hE500_0000 ^ {9'd0, a};
          @(negedge clk);
          ext_rsp_valid = 0;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] ptr(int tg, int ix);
    return {tg[8:0], ix[22:0]};
  endfunction

  task automatic access(bit we, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 100000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    cur_req = "R1";  // tag selects RAM, index is address
    access(1, ptr(2, 13), 32'h1111_AAAA);
    access(1, ptr(3, 5),  32'h2222_BBBB);
    access(1, ptr(4, 13), 32'h3333_CCCC);
    cur_req = "R2";
    access(0, ptr(2, 13), 0);
    access(0, ptr(3, 5),  0);
    access(0, ptr(4, 13), 0);
    idle(2);

    cur_req = "R3";  // truncation and independence across RAMs
    for (int i = 0; i < 32; i++) access(1, ptr(4, i), 32'h5A00_0000 + i * 37 + 5);
    for (int i = 0; i < 8; i++)  access(1, ptr(3, i), 32'hF0F0_0000 | (i * 4099));
    for (int i = 0; i < 32; i++) access(0, ptr(4, i), 0);
    for (int i = 0; i < 8; i++)  access(0, ptr(3, i), 0);
    access(0, ptr(2, 13), 0);
    idle(2);

    cur_req = "R10";  // read then write same word, alternating RAMs
    access(0, ptr(3, 5), 0);
    access(1, ptr(3, 5), 32'h0000_7E57);
    access(0, ptr(3, 5), 0);
    access(0, ptr(2, 13), 0);
    access(0, ptr(4, 13), 0);
    access(0, ptr(3, 5), 0);
    access(1, ptr(2, 0), 32'hABCD_0123);
    access(0, ptr(2, 0), 0);
    idle(2);

    cur_req = "R4";  // null pointer
    access(0, ptr(0, 13), 0);
    access(1, ptr(0, 13), 32'hDEAD_BEEF);
    access(0, ptr(2, 13), 0);
    idle(2);

    cur_req = "R8";  // index past depth aliases location 13 of RAM 0
    access(1, ptr(2, 29), 32'hBAD0_BAD0);
    access(0, ptr(2, 29), 0);
    access(0, ptr(3, 8), 0);
    access(1, ptr(4, 32), 32'h77);
    access(0, ptr(2, 13), 0);
    access(0, ptr(4, 0), 0);
    idle(2);

    cur_req = "R9";  // tags with no RAM
    access(0, ptr(5, 0), 0);
    access(1, ptr(511, 3), 32'h1);
    access(0, ptr(4, 3), 0);
    idle(2);

    cur_req = "R5";  // external write with slow acceptance
    ext_lat = 2;
    access(1, ptr(1, 23'h1234), 32'hCAFE_F00D);
    cur_req = "R7";
    access(0, ptr(2, 13), 0);
    idle(3);

    cur_req = "R6";  // external read, then on-chip read queued behind it
    ext_lat = 0; rsp_lat = 3;
    access(0, ptr(1, 77), 0);
    access(0, ptr(4, 13), 0);
    idle(2);
    ext_lat = 1; rsp_lat = 0;
    access(0, ptr(1, 23'h7FFFFF), 0);
    access(1, ptr(1, 9), 32'h0BAD_CAFE);
    access(0, ptr(3, 5), 0);
    idle(6);

    cur_req = "R11";  // reset mid-run
    rst = 1;
    idle(2);
    rst = 0;
    idle(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule